// File: doc/BRIEF.md
# Eight-Function Grouped-Mux ALU

This block is a purely combinational arithmetic and logic unit for a small datapath. It takes two operands of a parameterised width (four bits by default) and a three-bit operation code, and returns one result of the same width. It also returns a carry flag and a zero flag.

The code is decoded in two stages. The lowest code bit picks one member inside each of four function pairs: operand pass-through, constants, add/subtract and bitwise logic. The upper two code bits then pick which pair drives the result. Addition and subtraction share one adder, which subtracts by adding the inverted second operand with a carry-in of one. The block has no clock, no reset and no stored state. A consumer registers the result if it needs to.

Top module: `alu8_grouped`

## Requirements
- R1: Code 3'b000 drives the result with operand A.
- R2: Code 3'b001 drives the result with operand B.
- R3: Code 3'b010 drives an all-zeros result, and code 3'b011 drives an all-ones result.
- R4: Code 3'b100 drives (A + B) modulo 2^WIDTH. The carry flag is the bit that falls out above the top result bit.
- R5: Code 3'b101 drives (A - B) modulo 2^WIDTH. The carry flag is the adder carry of A + ~B + 1, which is 1 exactly when A >= B taken as unsigned values.
- R6: Code 3'b110 drives A AND B, and code 3'b111 drives A OR B, bit by bit.
- R7: For every code whose upper two bits are not 2'b10, the carry flag is 0.
- R8: For every code, the zero flag is 1 exactly when all result bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand (A) |
| opnd_b | input | WIDTH | Second operand (B) |
| op_code | input | 3 | Operation select: bits 2:1 pick the pair, bit 0 picks within the pair |
| result | output | WIDTH | Selected function output |
| carry_out | output | 1 | Adder carry for codes 100 and 101, otherwise 0 |
| zero_flag | output | 1 | High when the result is all zeros |

## Verification
The directed cases target the adder edges:
- All-ones plus all-ones and all-ones plus one must carry out. A design that drops the carry or widens the sum wrongly would report 0 there.
- Zero minus one must wrap to all ones with carry 0. A design that forgets the carry-in of one would be off by one.
- Equal operands must subtract to zero with carry 1, which exercises the zero flag on an arithmetic result.

The bench also sweeps every code with random operands. This exposes a swapped pair member, where bit 0 is wired backwards, or a swapped pair select, where bits 2:1 are misdecoded. It also exposes a carry flag that leaks out of the add/subtract pair.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [2:0] {
    OP_PASS_A = 3'b000,
    OP_PASS_B = 3'b001,
    OP_ZEROS  = 3'b010,
    OP_ONES   = 3'b011,
    OP_ADD    = 3'b100,
    OP_SUB    = 3'b101,
    OP_AND    = 3'b110,
    OP_OR     = 3'b111
  } alu_op_e;

  localparam int NUM_PAIRS = 4;
  localparam logic [1:0] PAIR_ARITH = 2'b10;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] add_a,
  input  logic [WIDTH-1:0] add_b,
  input  logic             do_sub,
  output logic [WIDTH-1:0] add_sum,
  output logic             add_cout
);
  localparam int EXT = WIDTH + 1;

  logic [EXT-1:0] total;
  logic [WIDTH-1:0] b_eff;

  always_comb begin
    b_eff = add_b ^ {WIDTH{do_sub}};
    total = {1'b0, add_a} + {1'b0, b_eff} + EXT'(do_sub);
    add_sum  = total[WIDTH-1:0];
    add_cout = total[WIDTH];
  end

  always_comb begin
    if (!do_sub) begin
      AST_ADD_SUM: assert ({add_cout, add_sum} == ({1'b0, add_a} + {1'b0, add_b})); // R4
    end else begin
      AST_SUB_DIFF: assert (add_sum == WIDTH'(add_a - add_b)); // R5
      AST_SUB_CARRY: assert (add_cout == (add_a >= add_b)); // R5
    end
  end
endmodule

// File: rtl/alu8_pair_sel.sv
module alu8_pair_sel #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cand_lo,
  input  logic [WIDTH-1:0] cand_hi,
  input  logic             pick_hi,
  output logic [WIDTH-1:0] pair_out
);
  always_comb begin
    pair_out = pick_hi ? cand_hi : cand_lo;
  end
endmodule

// File: rtl/alu8_grouped.sv
module alu8_grouped
  import alu8_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [2:0]       op_code,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             zero_flag
);
  logic [WIDTH-1:0] cand_lo [NUM_PAIRS];
  logic [WIDTH-1:0] cand_hi [NUM_PAIRS];
  logic [WIDTH-1:0] pair_res [NUM_PAIRS];
  logic [WIDTH-1:0] arith_sum;
  logic [WIDTH-1:0] arith_diff;
  logic             arith_cout_add;
  logic             arith_cout_sub;
  logic [1:0]       pair_idx;

  // One shared adder; bit 0 of the code chooses add or subtract.
  logic [WIDTH-1:0] shared_sum;
  logic             shared_cout;

  alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
    .add_a   (opnd_a),
    .add_b   (opnd_b),
    .do_sub  (op_code[0]),
    .add_sum (shared_sum),
    .add_cout(shared_cout)
  );

  always_comb begin
    arith_sum      = shared_sum;
    arith_diff     = shared_sum;
    arith_cout_add = shared_cout;
    arith_cout_sub = shared_cout;
    pair_idx       = op_code[2:1];

    cand_lo[0] = opnd_a;
    cand_hi[0] = opnd_b;
    cand_lo[1] = '0;
    cand_hi[1] = '1;
    cand_lo[2] = arith_sum;
    cand_hi[2] = arith_diff;
    cand_lo[3] = opnd_a & opnd_b;
    cand_hi[3] = opnd_a | opnd_b;
  end

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    alu8_pair_sel #(.WIDTH(WIDTH)) u_pair (
      .cand_lo (cand_lo[g]),
      .cand_hi (cand_hi[g]),
      .pick_hi (op_code[0]),
      .pair_out(pair_res[g])
    );
  end

  always_comb begin
    result    = pair_res[pair_idx];
    carry_out = (pair_idx == PAIR_ARITH) &&
                (op_code[0] ? arith_cout_sub : arith_cout_add);
    zero_flag = ~|result;
  end

  always_comb begin
    if (op_code == OP_PASS_A) AST_PASS_A: assert (result == opnd_a); // R1
    if (op_code == OP_PASS_B) AST_PASS_B: assert (result == opnd_b); // R2
    if (op_code == OP_ZEROS) AST_CONST_ZERO: assert ($countones(result) == 0); // R3
    if (op_code == OP_ONES) AST_CONST_ONES: assert ($countones(result) == WIDTH); // R3
    if (op_code == OP_AND) AST_LOGIC_AND: assert ((result & ~(opnd_a & opnd_b)) == '0 && (result | ~(opnd_a & opnd_b)) == '1); // R6
    if (op_code == OP_OR) AST_LOGIC_OR: assert (((result ^ opnd_a) & opnd_a) == '0 && (result & ~(opnd_a | opnd_b)) == '0); // R6
    if (op_code[2:1] != PAIR_ARITH) AST_CARRY_QUIET: assert (carry_out == 1'b0); // R7
    AST_ZERO_FLAG: assert (zero_flag == ($countones(result) == 0)); // R8
  end
endmodule

// File: tb/alu8_grouped_test.sv
module alu8_grouped_test;
  localparam int W = 4;
  localparam logic [W-1:0] ALL1 = '1;

  logic clk;
  logic rst_n;
  logic [W-1:0] a, b, res;
  logic [2:0] op;
  logic cy, zf;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  alu8_grouped #(.WIDTH(W)) uut (
    .opnd_a(a), .opnd_b(b), .op_code(op),
    .result(res), .carry_out(cy), .zero_flag(zf)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [W-1:0] exp_res(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    case (o)
      3'd0: return x;
      3'd1: return y;
      3'd2: return '0;
      3'd3: return ALL1;
      3'd4: return W'(x + y);
      3'd5: return W'(x - y);
      3'd6: return x & y;
      default: return x | y;
    endcase
  endfunction

  function automatic logic exp_cy(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    int unsigned s;
    if (o == 3'd4) begin
      s = int'(x) + int'(y);
      return s >= (1 << W);
    end
    if (o == 3'd5) return x >= y;
    return 1'b0;
  endfunction

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic apply(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] er;
    logic ec;
    @(negedge clk);
    op = o; a = x; b = y;
    #2;
    er = exp_res(o, x, y);
    ec = exp_cy(o, x, y);
    checks++;
    if (res !== er) begin
      fails++;
      $display("FAIL %s result op=%b a=%h b=%h actual=%h expected=%h", req_of(o), o, x, y, res, er);
    end
    checks++;
    if (cy !== ec) begin
      fails++;
      $display("FAIL %s/R7 carry op=%b a=%h b=%h actual=%b expected=%b", req_of(o), o, x, y, cy, ec);
    end
    checks++;
    if (zf !== (er == '0)) begin
      fails++;
      $display("FAIL R8 zero op=%b a=%h b=%h actual=%b expected=%b", o, x, y, zf, (er == '0));
    end
  endtask

  initial begin
    rst_n = 1'b0;
    op = 3'd0; a = '0; b = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // Start-up state: pass A of zero gives zero result and zero flag (R1, R8)
    apply(3'd0, '0, '0);
    // Directed corners
    apply(3'd4, ALL1, ALL1);      // R4 carry out
    apply(3'd4, ALL1, W'(1));     // R4 wrap to zero, carry 1, zero flag
    apply(3'd4, '0, '0);          // R4 no carry
    apply(3'd5, '0, W'(1));       // R5 borrow: all ones, carry 0
    apply(3'd5, W'(5), W'(5));    // R5 equal: zero, carry 1
    apply(3'd5, ALL1, '0);        // R5
    apply(3'd2, ALL1, ALL1);      // R3 zeros ignoring operands
    apply(3'd3, '0, '0);          // R3 ones ignoring operands
    apply(3'd6, W'(4'hA), W'(4'h5)); // R6 AND gives zero
    apply(3'd7, W'(4'hA), W'(4'h5)); // R6 OR gives ones
    apply(3'd1, ALL1, '0);        // R2 with zero flag
    apply(3'd7, ALL1, ALL1);      // R7 carry stays 0 for logic code
    void'($urandom(32'd20240611));
    for (int i = 0; i < 400; i++) begin
      apply(3'($urandom % 8), W'($urandom), W'($urandom));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired before stimulus completed");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule